// File: doc/BRIEF.md
# PAL Raster Timing Generator

This block produces the raster timing for a PAL-style display from a 16 MHz pixel clock. A horizontal counter steps through the 1024 cycles of a 64 µs scanline. A vertical counter steps through the 312 lines of a field. From these two counters the block decodes four signals: an active-low horizontal sync, an active-low composite sync, a display-enable window for pixel output, and a fetch window for screen memory reads. The fetch window runs one memory slot ahead of the pixels. The pixel window begins at a cycle offset that is a multiple of the 8-cycle memory slot, so fetches and pixels stay in step. The block also outputs the pixel column and the display line that the pixel logic indexes.

Counter position 0 on both axes is the start of a sync pulse. Software can remove lines from the top and the bottom of the picture through an 8-bit blanking value. The block samples this value only when a new field begins, so a write in the middle of a field cannot tear the picture. A one-cycle external sync pulse returns both counters to their sync-start position, which lets the raster lock to another video source.

Top module: `pal_raster`

## Requirements
- R1: The horizontal counter counts 0 to H_TOTAL-1 (default 1024) and wraps to 0; consecutive falling edges of `hs_n` are H_TOTAL cycles apart.
- R2: The vertical counter advances once per line, when the horizontal counter wraps, and counts 0 to V_TOTAL-1 (default 312).
- R3: `hs_n` is low exactly while the horizontal count is below HS_LEN (default 75).
- R4: `csync_n` is low while the horizontal count is below HS_LEN or the vertical count is below VS_LEN (default 3), and high otherwise.
- R5: `de` is high exactly when the horizontal count lies in [PIX_START, PIX_START+PIX_LEN) (defaults 264 and 640) on a visible line. While `de` is high, `col` equals the horizontal count minus PIX_START; otherwise `col` is 0.
- R6: A line is visible when its vertical count lies in [DISP_START+top, DISP_START+DISP_LINES-bottom) (defaults 38 and 256). While `de` is high, `line` equals the vertical count minus DISP_START; otherwise `line` is 0.
- R7: `fetch` is high exactly when the horizontal count lies in [PIX_START-SLOT, PIX_START+PIX_LEN-SLOT) on a visible line (SLOT defaults to 8), so it rises one slot before `de`.
- R8: `blank_cfg[7:4]` holds the number of lines removed at the top of the display window and `blank_cfg[3:0]` the number removed at the bottom, each 0 to 15. Removed lines raise neither `de` nor `fetch`.
- R9: The blanking value takes effect only where a field starts, that is, at the edge where both counters wrap or at an external sync. A change at any other time has no effect until then.
- R10: When `ext_sync` is high at a clock edge, both counters become 0 on that edge and the blanking value is sampled.
- R11: While `rst_n` is low, both counters and the stored blanking counts are 0, so `hs_n` and `csync_n` are low and `de` and `fetch` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_sync | input | 1 | Genlock pulse; restarts both counters at sync start |
| blank_cfg | input | 8 | Top blank count [7:4], bottom blank count [3:0] |
| hs_n | output | 1 | Horizontal sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| de | output | 1 | Pixel display enable |
| fetch | output | 1 | Screen memory fetch window |
| col | output | $clog2(PIX_LEN) | Pixel column within the window |
| line | output | $clog2(DISP_LINES) | Display line within the window |

## Verification
On every cycle the assertions check several invariants: the horizontal wrap, that a horizontal sync always appears on composite sync, that the column starts at 0 when `de` rises, that `fetch` is already high one cycle before `de` rises, that the blanking counts hold outside field starts, and the counter restart after a genlock pulse. Other behaviour can only be shown by the bench's scenarios, which compare every output against an independent arithmetic model on every cycle: whether a given blanking value removes the right lines, that a value written mid-field waits for the next field, and the exact sync widths.

// File: rtl/pal_raster.sv
module pal_raster #(
  parameter int H_TOTAL    = 1024,
  parameter int HS_LEN     = 75,
  parameter int PIX_START  = 264,
  parameter int PIX_LEN    = 640,
  parameter int SLOT       = 8,
  parameter int V_TOTAL    = 312,
  parameter int VS_LEN     = 3,
  parameter int DISP_START = 38,
  parameter int DISP_LINES = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ext_sync,
  input  logic [7:0]                    blank_cfg,
  output logic                          hs_n,
  output logic                          csync_n,
  output logic                          de,
  output logic                          fetch,
  output logic [$clog2(PIX_LEN)-1:0]    col,
  output logic [$clog2(DISP_LINES)-1:0] line
);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam int CW = $clog2(PIX_LEN);
  localparam int LW = $clog2(DISP_LINES);

  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic [3:0]    top_q, bot_q;
  logic          vis, in_pix, in_fetch;

  wire h_end = (h == HW'(H_TOTAL - 1));
  wire v_end = (v == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h <= '0;
      v <= '0;
      top_q <= '0;
      bot_q <= '0;
    end else if (ext_sync) begin
      h <= '0;
      v <= '0;
      top_q <= blank_cfg[7:4];
      bot_q <= blank_cfg[3:0];
    end else begin
      h <= h_end ? '0 : h + 1'b1;
      if (h_end) begin
        v <= v_end ? '0 : v + 1'b1;
        if (v_end) begin
          top_q <= blank_cfg[7:4];
          bot_q <= blank_cfg[3:0];
        end
      end
    end
  end

  always_comb begin
    vis      = (int'(v) >= DISP_START + int'(top_q)) &&
               (int'(v) <  DISP_START + DISP_LINES - int'(bot_q));
    in_pix   = (int'(h) >= PIX_START) && (int'(h) < PIX_START + PIX_LEN);
    in_fetch = (int'(h) >= PIX_START - SLOT) && (int'(h) < PIX_START + PIX_LEN - SLOT);
  end

  assign hs_n    = !(int'(h) < HS_LEN);
  assign csync_n = hs_n && !(int'(v) < VS_LEN);
  assign de      = vis && in_pix;
  assign fetch   = vis && in_fetch;
  assign col     = de ? CW'(int'(h) - PIX_START) : '0;
  assign line    = de ? LW'(int'(v) - DISP_START) : '0;

  a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (h_end && !ext_sync) |=> (h == '0));
  a_r2_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_end && !ext_sync) |=> $stable(v));
  a_r4_hs_in_csync: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_n |-> !csync_n);
  a_r5_col_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> (col == '0));
  a_r7_fetch_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> $past(fetch));
  a_r9_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sync && !(h_end && v_end)) |=> ($stable(top_q) && $stable(bot_q)));
  a_r10_genlock: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sync |=> (h == '0 && v == '0 && !csync_n));
endmodule

// File: tb/test_pal_raster.sv
`timescale 1ns/1ps
module test_pal_raster;
  localparam int HT = 64, HS = 5, PS = 16, PL = 32, SL = 8;
  localparam int VT = 60, VS = 3, DS = 6, DL = 40;

  logic clk = 0, rst_n = 0, ext_sync = 0;
  logic [7:0] blank_cfg = 8'h00;
  logic hs_n, csync_n, de, fetch;
  logic [4:0] col;
  logic [5:0] line;

  int total = 0, bad = 0, cyc = 0;
  int eh = 0, ev = 0, etop = 0, ebot = 0;
  int last_fall = -1;
  logic prev_hs = 1'b1, done = 1'b0;

  always #2.5 clk = ~clk;

  pal_raster #(.H_TOTAL(HT), .HS_LEN(HS), .PIX_START(PS), .PIX_LEN(PL), .SLOT(SL),
               .V_TOTAL(VT), .VS_LEN(VS), .DISP_START(DS), .DISP_LINES(DL)) i_pal_raster (
    .clk(clk), .rst_n(rst_n), .ext_sync(ext_sync), .blank_cfg(blank_cfg),
    .hs_n(hs_n), .csync_n(csync_n), .de(de), .fetch(fetch), .col(col), .line(line));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      eh <= 0; ev <= 0; etop <= 0; ebot <= 0;
    end else if (ext_sync) begin
      eh <= 0; ev <= 0; etop <= int'(blank_cfg[7:4]); ebot <= int'(blank_cfg[3:0]);
    end else begin
      eh <= (eh == HT-1) ? 0 : eh + 1;
      if (eh == HT-1) begin
        ev <= (ev == VT-1) ? 0 : ev + 1;
        if (ev == VT-1) begin
          etop <= int'(blank_cfg[7:4]); ebot <= int'(blank_cfg[3:0]);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done && cyc > 0) begin
      bit vis, xde, xf, xhs, xcs;
      int xcol, xline;
      vis   = (ev >= DS + etop) && (ev < DS + DL - ebot);
      xhs   = !(eh < HS);
      xcs   = !(eh < HS || ev < VS);
      xde   = vis && eh >= PS && eh < PS + PL;
      xf    = vis && eh >= PS - SL && eh < PS + PL - SL;
      xcol  = xde ? eh - PS : 0;
      xline = xde ? ev - DS : 0;
      if (!rst_n)
        chk(!hs_n && !csync_n && !de && !fetch, "R11 reset outputs",
            {hs_n, csync_n, de, fetch}, 0);
      chk(hs_n == xhs, "R3 hs_n", hs_n, xhs);
      chk(csync_n == xcs, "R4 csync_n", csync_n, xcs);
      chk(de == xde, "R5/R8 de", de, xde);
      chk(int'(col) == xcol, "R5 col", col, xcol);
      chk(int'(line) == xline, "R6/R2 line", line, xline);
      chk(fetch == xf, "R7/R8 fetch", fetch, xf);
      if (ext_sync) last_fall = -1;
      else if (rst_n && prev_hs && !hs_n) begin
        if (last_fall >= 0) chk(cyc - last_fall == HT, "R1 line period", cyc - last_fall, HT);
        last_fall = cyc;
      end
      prev_hs = hs_n;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(4);
    rst_n = 1;
    run(HT*VT + 10);
    blank_cfg = 8'h3A;                 // R9: mid-field write, effective next field
    run(HT*VT);
    blank_cfg = 8'hFF;                 // R8 maximum blanking
    run(HT*VT);
    blank_cfg = 8'hF0;
    run(HT*VT);
    blank_cfg = 8'h0F;
    run(HT*20 + 7);
    ext_sync = 1;                      // R10 genlock pulse mid-field
    run(1);
    ext_sync = 0;
    blank_cfg = 8'h21;
    run(HT*VT + HT*5 + 3);
    ext_sync = 1;                      // R10 back-to-back pulses
    run(2);
    ext_sync = 0;
    run(HT*VT + 20);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule